// File: doc/BRIEF.md
# Device Access Trap and Idle Timer

This block watches every bus cycle for accesses to one programmable device window. The window can sit in memory space or in I/O space. From those accesses it raises two kinds of power-management interrupt request.

The first is an access trap. It asserts on any matching cycle while the trap is enabled. The second is an inactivity alarm, driven by a 16-bit countdown. The countdown steps down once per one-second tick and is reloaded by every matching access. When it runs out, the device is taken to be idle.

Software sets the window, the cycle filter, the reload count and the two enables through a small register port. It reads two sticky status flags, which it clears by writing ones to them. A single request output combines the flags whose sources are enabled.

Top module: `acc_watch`

## Requirements
- R1: After reset, every register reads zero, both status flags are low and `smiReq` is low.
- R2: Register selects on `regAddr`:
  - 0: 32-bit base address.
  - 1: 8-bit control.
  - 2: 16-bit reload count.
  - 3: enables, with bit 0 for the idle timer and bit 1 for the trap.
  - 4: status, with bit 0 for idle and bit 1 for trap.
  - 5: live countdown value, read only.
  - Writable registers read back what was written, zero-extended.
- R3: In I/O mode (control bit 7 = 0), a cycle with `busIsMem` = 0 matches only under these conditions:
  - Address bits 31:5 equal the base.
  - Each address bit k in 4:0 equals base bit k, unless control bit k is 1.
  - Write cycles also need control bit 6 set, and read cycles need control bit 5 set.
- R4: In memory mode (control bit 7 = 1), a cycle with `busIsMem` = 1 matches when address bits 31:16 equal the base. For each k in 0..6, address bit 9+k must also equal the base, unless control bit k is 1. Address bits 8:0 are never compared, and reads and writes both match.
- R5: No match occurs while `busValid` is low, or when `busIsMem` disagrees with control bit 7.
- R6: With the trap enabled, a matching cycle sets the trap flag one clock later. With the trap disabled, matching cycles leave the trap flag alone.
- R7: Two events load the countdown from the reload count: a write to the enable register with bit 0 set, and a matching cycle while the idle timer is enabled.
- R8: While running, each tick decrements the countdown. A reload count of N ≥ 1 expires on the Nth tick, and a count of 0 expires on the first tick. On expiry the idle flag is set, and the countdown stays at 0 and halts until it is reloaded.
- R9: A matching cycle in the same clock as a tick reloads the countdown rather than decrementing it.
- R10: Writing 1 to a status bit clears that flag. A set event in the same clock wins over the clear.
- R11: `smiReq` is high exactly when (idle flag and idle enable) or (trap flag and trap enable).
- R12: Writing the reload count does not disturb a running countdown. With the idle timer disabled, ticks neither change the countdown nor set the idle flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select for write and read |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational on regAddr |
| busValid | input | 1 | Observed bus cycle is valid this clock |
| busAddr | input | 32 | Observed cycle address |
| busIsMem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| busWrite | input | 1 | 1 = write cycle, 0 = read cycle |
| tick | input | 1 | One-clock pulse per second |
| idleFlag | output | 1 | Sticky idle expiry status |
| trapFlag | output | 1 | Sticky access trap status |
| smiReq | output | 1 | Combined power-management interrupt request |

## Verification
Three pairs of events can land in the same clock, and each needs a defined winner:
- **Matching access and tick.** The reload must beat the decrement. This is provoked by running a countdown partway, then presenting a matching access together with a tick; the countdown must read back the full reload count. The same collision at a count of one must not expire.
- **Status set and clear.** A trap match is issued in the same cycle as a write-1-clear of the trap flag, and the flag must remain set.
- **Random overlap.** Random traffic keeps ticks, near-window addresses and register writes overlapping. Each clock is judged against a bench model written from the requirements.

// File: rtl/acc_watch_pkg.sv
package acc_watch_pkg;

  localparam int SEL_W = 3;

  localparam logic [SEL_W-1:0] SEL_BASE   = 3'd0;
  localparam logic [SEL_W-1:0] SEL_CTL    = 3'd1;
  localparam logic [SEL_W-1:0] SEL_COUNT  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_ENABLE = 3'd3;
  localparam logic [SEL_W-1:0] SEL_STATUS = 3'd4;
  localparam logic [SEL_W-1:0] SEL_LIVE   = 3'd5;

  // Enable and status bit positions
  localparam int BIT_IDLE = 0;
  localparam int BIT_TRAP = 1;

  // Strobes from control to the countdown datapath
  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic zeroCnt;
  } cntStrobe_t;

endpackage

// File: rtl/acc_watch_dp.sv
module acc_watch_dp
  import acc_watch_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int CTL_W      = 8,
  parameter int IO_MASK_W  = 5,
  parameter int MEM_LSB    = 9,
  parameter int MEM_MASK_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [SEL_W-1:0]  regAddr,
  input  logic [ADDR_W-1:0] regWdata,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busIsMem,
  input  logic              busWrite,
  input  cntStrobe_t        strobe,
  output logic              matchHit,
  output logic              cntLow,
  output logic [ADDR_W-1:0] baseReg,
  output logic [CTL_W-1:0]  ctlReg,
  output logic [CNT_W-1:0]  countReg,
  output logic [CNT_W-1:0]  cntVal
);

  localparam int MEM_HI   = MEM_LSB + MEM_MASK_W;
  localparam int MODE_BIT = CTL_W - 1;
  localparam int WR_BIT   = CTL_W - 2;
  localparam int RD_BIT   = CTL_W - 3;

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg  <= '0;
      ctlReg   <= '0;
      countReg <= '0;
    end else if (regWe) begin
      if (regAddr == SEL_BASE)  baseReg  <= regWdata;
      if (regAddr == SEL_CTL)   ctlReg   <= regWdata[CTL_W-1:0];
      if (regAddr == SEL_COUNT) countReg <= regWdata[CNT_W-1:0];
    end
  end

  // Per-bit address compare, one variant per mode
  logic [ADDR_W-1:0] ioBitOk;
  logic [ADDR_W-1:0] memBitOk;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    logic bitDiff;
    assign bitDiff = busAddr[i] ^ baseReg[i];

    if (i < IO_MASK_W) begin : g_ioMask
      assign ioBitOk[i] = !bitDiff || ctlReg[i];
    end else begin : g_ioExact
      assign ioBitOk[i] = !bitDiff;
    end

    if (i < MEM_LSB) begin : g_memIgnore
      assign memBitOk[i] = 1'b1;
    end else if (i < MEM_HI) begin : g_memMask
      assign memBitOk[i] = !bitDiff || ctlReg[i-MEM_LSB];
    end else begin : g_memExact
      assign memBitOk[i] = !bitDiff;
    end
  end

  logic memMode;
  logic spaceOk;
  logic dirOk;
  logic addrOk;

  always_comb begin
    memMode  = ctlReg[MODE_BIT];
    spaceOk  = (busIsMem == memMode);
    dirOk    = memMode ? 1'b1 : (busWrite ? ctlReg[WR_BIT] : ctlReg[RD_BIT]);
    addrOk   = memMode ? (&memBitOk) : (&ioBitOk);
    matchHit = busValid && spaceOk && dirOk && addrOk;
  end

  // Idle countdown
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (strobe.loadCnt) begin
      cntVal <= countReg;
    end else if (strobe.zeroCnt) begin
      cntVal <= '0;
    end else if (strobe.decCnt) begin
      cntVal <= cntVal - CNT_W'(1);
    end
  end

  assign cntLow = (cntVal <= CNT_W'(1));

  a_r8_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.decCnt && !strobe.loadCnt && !strobe.zeroCnt)
      |=> (cntVal == $past(cntVal) - CNT_W'(1)));

  a_r7_load_value: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCnt |=> (cntVal == $past(countReg)));

  a_r5_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |-> !matchHit);

  a_r5_space_agree: assert property (@(posedge clk) disable iff (!rstN)
    matchHit |-> (busIsMem == ctlReg[MODE_BIT]));

endmodule

// File: rtl/acc_watch_ctl.sv
module acc_watch_ctl
  import acc_watch_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [SEL_W-1:0] regAddr,
  input  logic [1:0]       wrBits,
  input  logic             matchHit,
  input  logic             tick,
  input  logic             cntLow,
  output cntStrobe_t       strobe,
  output logic             idleEn,
  output logic             trapEn,
  output logic             idleSt,
  output logic             trapSt,
  output logic             smiReq
);

  logic enWrite;
  logic stWrite;
  logic running;
  logic stepOk;
  logic expire;

  always_comb begin
    enWrite        = regWe && (regAddr == SEL_ENABLE);
    stWrite        = regWe && (regAddr == SEL_STATUS);
    strobe.loadCnt = (enWrite && wrBits[BIT_IDLE]) || (idleEn && matchHit);
    stepOk         = idleEn && running && tick && !strobe.loadCnt;
    expire         = stepOk && cntLow;
    strobe.zeroCnt = expire;
    strobe.decCnt  = stepOk && !cntLow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleEn <= 1'b0;
      trapEn <= 1'b0;
    end else if (enWrite) begin
      idleEn <= wrBits[BIT_IDLE];
      trapEn <= wrBits[BIT_TRAP];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
    end else if (enWrite) begin
      running <= wrBits[BIT_IDLE];
    end else if (idleEn && matchHit) begin
      running <= 1'b1;
    end else if (expire) begin
      running <= 1'b0;
    end
  end

  // Sticky flags, set wins over write-1-clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleSt <= 1'b0;
      trapSt <= 1'b0;
    end else begin
      idleSt <= expire || (idleSt && !(stWrite && wrBits[BIT_IDLE]));
      trapSt <= (trapEn && matchHit) || (trapSt && !(stWrite && wrBits[BIT_TRAP]));
    end
  end

  assign smiReq = (idleSt && idleEn) || (trapSt && trapEn);

  a_r6_trap_sets: assert property (@(posedge clk) disable iff (!rstN)
    (trapEn && matchHit) |=> trapSt);

  a_r8_expiry: assert property (@(posedge clk) disable iff (!rstN)
    (idleEn && running && tick && cntLow && !matchHit && !enWrite)
      |=> (idleSt && !running));

  a_r9_reload_wins: assert property (@(posedge clk) disable iff (!rstN)
    (idleEn && matchHit && tick && !enWrite) |=> running);

  a_r10_clear: assert property (@(posedge clk) disable iff (!rstN)
    (stWrite && wrBits[BIT_TRAP] && !(trapEn && matchHit)) |=> !trapSt);

  a_r12_halt_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (!idleEn && !enWrite) |=> !$rose(idleSt));

endmodule

// File: rtl/acc_watch.sv
module acc_watch
  import acc_watch_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int CTL_W      = 8,
  parameter int IO_MASK_W  = 5,
  parameter int MEM_LSB    = 9,
  parameter int MEM_MASK_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [SEL_W-1:0]  regAddr,
  input  logic [ADDR_W-1:0] regWdata,
  output logic [ADDR_W-1:0] regRdata,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busIsMem,
  input  logic              busWrite,
  input  logic              tick,
  output logic              idleFlag,
  output logic              trapFlag,
  output logic              smiReq
);

  cntStrobe_t        strobe;
  logic              matchHit;
  logic              cntLow;
  logic [ADDR_W-1:0] baseReg;
  logic [CTL_W-1:0]  ctlReg;
  logic [CNT_W-1:0]  countReg;
  logic [CNT_W-1:0]  cntVal;
  logic              idleEn;
  logic              trapEn;

  acc_watch_dp #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CTL_W(CTL_W),
    .IO_MASK_W(IO_MASK_W), .MEM_LSB(MEM_LSB), .MEM_MASK_W(MEM_MASK_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .busValid(busValid), .busAddr(busAddr), .busIsMem(busIsMem), .busWrite(busWrite),
    .strobe(strobe), .matchHit(matchHit), .cntLow(cntLow),
    .baseReg(baseReg), .ctlReg(ctlReg), .countReg(countReg), .cntVal(cntVal)
  );

  acc_watch_ctl u_ctl (
    .clk(clk), .rstN(rstN),
    .regWe(regWe), .regAddr(regAddr), .wrBits(regWdata[1:0]),
    .matchHit(matchHit), .tick(tick), .cntLow(cntLow),
    .strobe(strobe), .idleEn(idleEn), .trapEn(trapEn),
    .idleSt(idleFlag), .trapSt(trapFlag), .smiReq(smiReq)
  );

  always_comb begin
    regRdata = '0;
    case (regAddr)
      SEL_BASE:   regRdata = baseReg;
      SEL_CTL:    regRdata = ADDR_W'(ctlReg);
      SEL_COUNT:  regRdata = ADDR_W'(countReg);
      SEL_ENABLE: regRdata = ADDR_W'({trapEn, idleEn});
      SEL_STATUS: regRdata = ADDR_W'({trapFlag, idleFlag});
      SEL_LIVE:   regRdata = ADDR_W'(cntVal);
      default:    regRdata = '0;
    endcase
  end

  a_r11_req_source: assert property (@(posedge clk) disable iff (!rstN)
    smiReq |-> (idleFlag || trapFlag));

endmodule

// File: tb/acc_watch_bench.sv
module acc_watch_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWe;
  logic [2:0]  regAddr;
  logic [31:0] regWdata;
  logic [31:0] regRdata;
  logic        busValid;
  logic [31:0] busAddr;
  logic        busIsMem;
  logic        busWrite;
  logic        tick;
  logic        idleFlag;
  logic        trapFlag;
  logic        smiReq;

  always #10 clk = ~clk;

  acc_watch u_acc_watch (
    .clk(clk), .rstN(rstN),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .busValid(busValid), .busAddr(busAddr), .busIsMem(busIsMem), .busWrite(busWrite),
    .tick(tick), .idleFlag(idleFlag), .trapFlag(trapFlag), .smiReq(smiReq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [2:0] rdSel = 3'd0;

  // Reference state
  logic [31:0] mBase;
  logic [7:0]  mCtl;
  logic [15:0] mCount;
  logic [15:0] mLive;
  bit mIdleEn, mTrapEn, mRun, mIdleSt, mTrapSt;

  function automatic bit expMatch(logic [31:0] b, logic [7:0] c, logic [31:0] a, bit m, bit w);
    logic [31:0] care;
    if (c[7] != m) return 1'b0;
    if (c[7]) begin
      care = 32'hFFFF_0000 | ({25'b0, ~c[6:0]} << 9);
      return ((a ^ b) & care) == 32'h0;
    end
    if (w && !c[6]) return 1'b0;
    if (!w && !c[5]) return 1'b0;
    care = 32'hFFFF_FFE0 | {27'b0, ~c[4:0]};
    return ((a ^ b) & care) == 32'h0;
  endfunction

  function automatic logic [31:0] expRead(logic [2:0] s);
    case (s)
      3'd0: return mBase;
      3'd1: return {24'b0, mCtl};
      3'd2: return {16'b0, mCount};
      3'd3: return {30'b0, mTrapEn, mIdleEn};
      3'd4: return {30'b0, mTrapSt, mIdleSt};
      3'd5: return {16'b0, mLive};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mBase = 0; mCtl = 0; mCount = 0; mLive = 0;
    mIdleEn = 0; mTrapEn = 0; mRun = 0; mIdleSt = 0; mTrapSt = 0;
  endtask

  // One clock: drive at negedge, update model, sample at next negedge
  task automatic cycle(bit we, logic [2:0] ra, logic [31:0] wd, bit bv,
                       logic [31:0] ba, bit bm, bit bw, bit tk);
    bit hit, enW, stW, expd;
    logic [31:0] nBase; logic [7:0] nCtl; logic [15:0] nCount, nLive;
    bit nIdleEn, nTrapEn, nRun, nI, nT;
    regWe = we; regAddr = we ? ra : rdSel; regWdata = wd;
    busValid = bv; busAddr = ba; busIsMem = bm; busWrite = bw; tick = tk;
    hit = bv && expMatch(mBase, mCtl, ba, bm, bw);
    enW = we && ra == 3'd3; stW = we && ra == 3'd4; expd = 0;
    nBase = mBase; nCtl = mCtl; nCount = mCount; nLive = mLive;
    nIdleEn = mIdleEn; nTrapEn = mTrapEn; nRun = mRun; nI = mIdleSt; nT = mTrapSt;
    if (enW && wd[0]) begin nLive = mCount; nRun = 1; end
    else if (mIdleEn && hit) begin nLive = mCount; nRun = 1; end
    else if (mIdleEn && mRun && tk) begin
      if (mLive <= 16'd1) begin nLive = 0; nRun = 0; expd = 1; end
      else nLive = mLive - 16'd1;
    end
    if (enW && !wd[0]) nRun = 0;
    if (stW) begin
      if (wd[0]) nI = 0;
      if (wd[1]) nT = 0;
    end
    if (expd) nI = 1;
    if (mTrapEn && hit) nT = 1;
    if (we) begin
      case (ra)
        3'd0: nBase = wd;
        3'd1: nCtl = wd[7:0];
        3'd2: nCount = wd[15:0];
        3'd3: begin nIdleEn = wd[0]; nTrapEn = wd[1]; end
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    mBase = nBase; mCtl = nCtl; mCount = nCount; mLive = nLive;
    mIdleEn = nIdleEn; mTrapEn = nTrapEn; mRun = nRun; mIdleSt = nI; mTrapSt = nT;
    chk(trapFlag == mTrapSt, "R6 trap flag", 32'(trapFlag), 32'(mTrapSt));
    chk(idleFlag == mIdleSt, "R8 idle flag", 32'(idleFlag), 32'(mIdleSt));
    chk(smiReq == ((mIdleSt && mIdleEn) || (mTrapSt && mTrapEn)), "R11 request",
        32'(smiReq), 32'((mIdleSt && mIdleEn) || (mTrapSt && mTrapEn)));
    chk(regRdata == expRead(regAddr), "R2 readback", regRdata, expRead(regAddr));
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    cycle(1, a, d, 0, 32'h0, 0, 0, 0);
  endtask

  task automatic idle(logic [2:0] s);
    rdSel = s;
    cycle(0, 3'd0, 32'h0, 0, 32'h0, 0, 0, 0);
  endtask

  task automatic acc(logic [31:0] a, bit m, bit w, bit tk);
    cycle(0, 3'd0, 32'h0, 1, a, m, w, tk);
  endtask

  task automatic tickOnly();
    cycle(0, 3'd0, 32'h0, 0, 32'h0, 0, 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 0; regWe = 0; regAddr = 0; regWdata = 0;
    busValid = 0; busAddr = 0; busIsMem = 0; busWrite = 0; tick = 0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;

    // R1 reset state
    for (int s = 0; s < 6; s++) begin
      idle(3'(s));
      chk(regRdata == 32'h0, "R1 reset register", regRdata, 32'h0);
    end
    chk(!smiReq && !idleFlag && !trapFlag, "R1 reset flags",
        {29'b0, smiReq, idleFlag, trapFlag}, 32'h0);

    // R3 I/O mode
    wr(3'd0, 32'h1234_5660);
    wr(3'd1, 32'h0000_0063);      // writes+reads, mask addr bits 1:0
    wr(3'd3, 32'h2);              // trap on
    acc(32'h1234_5663, 0, 1, 0);
    chk(trapFlag == 1'b1, "R3 io masked match", 32'(trapFlag), 32'h1);
    wr(3'd4, 32'h2);
    chk(trapFlag == 1'b0, "R10 clear trap", 32'(trapFlag), 32'h0);
    acc(32'h1234_5664, 0, 1, 0);
    chk(trapFlag == 1'b0, "R3 unmasked bit 2", 32'(trapFlag), 32'h0);
    wr(3'd1, 32'h0000_0040);      // writes only
    acc(32'h1234_5660, 0, 0, 0);
    chk(trapFlag == 1'b0, "R3 read filtered", 32'(trapFlag), 32'h0);
    acc(32'h1234_5660, 1, 1, 0);
    chk(trapFlag == 1'b0, "R5 space mismatch", 32'(trapFlag), 32'h0);
    cycle(0, 3'd0, 32'h0, 0, 32'h1234_5660, 0, 1, 0);
    chk(trapFlag == 1'b0, "R5 invalid cycle", 32'(trapFlag), 32'h0);

    // R4 memory mode
    wr(3'd0, 32'h0004_0000);
    wr(3'd1, 32'h0000_0081);      // mask addr bit 9
    acc(32'h0004_03FF, 1, 0, 0);
    chk(trapFlag == 1'b1, "R4 mem match", 32'(trapFlag), 32'h1);
    wr(3'd4, 32'h2);
    acc(32'h0004_0400, 1, 1, 0);
    chk(trapFlag == 1'b0, "R4 bit 10 compared", 32'(trapFlag), 32'h0);

    // R10 set wins over clear
    cycle(1, 3'd4, 32'h2, 1, 32'h0004_0000, 1, 1, 0);
    chk(trapFlag == 1'b1, "R10 set beats clear", 32'(trapFlag), 32'h1);
    wr(3'd3, 32'h0);              // trap off
    chk(smiReq == 1'b0, "R11 gated by enable", 32'(smiReq), 32'h0);
    wr(3'd4, 32'h3);
    acc(32'h0004_0000, 1, 1, 0);
    chk(trapFlag == 1'b0, "R6 disabled trap", 32'(trapFlag), 32'h0);

    // R7, R9 idle countdown
    wr(3'd2, 32'd5);
    wr(3'd3, 32'h1);
    idle(3'd5);
    chk(regRdata == 32'd5, "R7 load on enable", regRdata, 32'd5);
    tickOnly(); tickOnly();
    chk(regRdata == 32'd3, "R8 decrement", regRdata, 32'd3);
    acc(32'h0004_0000, 1, 0, 1);
    chk(regRdata == 32'd5, "R9 reload beats tick", regRdata, 32'd5);
    wr(3'd2, 32'd9);
    idle(3'd5);
    chk(regRdata == 32'd5, "R12 count write no effect", regRdata, 32'd5);
    wr(3'd2, 32'd1);
    acc(32'h0004_0000, 1, 1, 0);
    chk(regRdata == 32'd1, "R7 reload on access", regRdata, 32'd1);
    tickOnly();
    chk(idleFlag == 1'b1 && regRdata == 32'd0, "R8 count one expires",
        {31'b0, idleFlag}, 32'h1);
    wr(3'd4, 32'h1);
    tickOnly();
    chk(idleFlag == 1'b0, "R8 halted after expiry", 32'(idleFlag), 32'h0);
    wr(3'd2, 32'd0);
    wr(3'd3, 32'h1);
    tickOnly();
    chk(idleFlag == 1'b1, "R8 zero count first tick", 32'(idleFlag), 32'h1);
    chk(smiReq == 1'b1, "R11 idle request", 32'(smiReq), 32'h1);
    wr(3'd4, 32'h1);
    wr(3'd2, 32'd4);
    wr(3'd3, 32'h1);
    wr(3'd3, 32'h0);
    tickOnly(); tickOnly(); tickOnly(); tickOnly(); tickOnly();
    idle(3'd5);
    chk(regRdata == 32'd4 && !idleFlag, "R12 disabled holds", regRdata, 32'd4);

    // Random traffic near the window
    for (int n = 0; n < 4000; n++) begin
      bit we, bv, bm, bw, tk;
      logic [2:0] ra;
      logic [31:0] wd, ba, flip;
      we = ($urandom % 8) == 0;
      ra = 3'($urandom % 5);
      case (ra)
        3'd2: wd = $urandom % 6;
        3'd3, 3'd4: wd = $urandom % 4;
        3'd1: wd = $urandom % 256;
        default: wd = ($urandom % 4 == 0) ? $urandom : (mBase ^ ($urandom & 32'h0003_FFFF));
      endcase
      case ($urandom % 4)
        0: flip = 32'h0;
        1: flip = $urandom & 32'h1F;
        2: flip = $urandom & 32'hFFFF;
        default: flip = $urandom;
      endcase
      ba = mBase ^ flip;
      bv = $urandom % 2; bm = $urandom % 2; bw = $urandom % 2;
      tk = ($urandom % 4) == 0;
      rdSel = 3'($urandom % 6);
      cycle(we, ra, wd, bv, ba, bm, bw, tk);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule